// File: doc/BRIEF.md
# Add-with-Carry Instruction Sequencer

This block is a cycle-exact execution engine for an 8-bit accumulator machine that understands one operation: add the addressed byte and the carry flag into the accumulator. It reads program and operand bytes through a byte-wide synchronous read port. The port has one cycle of latency. The block decodes the addressing mode from the opcode and, for the stack-relative forms, from a second byte that follows a prefix. It then forms the effective address, fetches the operand, updates the accumulator and the five condition flags, and moves the program counter past the instruction.

Every instruction takes a fixed number of clock cycles that depends on its mode. Any cycle beyond those needed for fetches is an internal cycle. The block starts the read of the next opcode in the same cycle that it commits a result, so instructions run back to back with no gap. A synchronous reset loads the starting program counter, index register, stack pointer, accumulator and carry from input ports. An unknown opcode stops the block for good and raises a flag.

Top module: `adc_seq`

## Requirements
- R1: Each instruction computes acc + operand + C. The low 8 bits go to the accumulator, and flag_c takes the carry out of bit 7. The accumulator changes only when an instruction completes.
- R2: On completion, flag_h takes the carry out of bit 3 of the sum, and flag_n takes bit 7 of the result. flag_z is set exactly when the result is 0x00. flag_v is set when both addends share a sign bit that differs from bit 7 of the result.
- R3: Opcode 0xA9 is the immediate form. It is 2 bytes long and takes 2 cycles, and its operand is the byte after the opcode.
- R4: Opcode 0xB9 is the zero-page form. It is 2 bytes long and takes 3 cycles, and it reads address 0x00 concatenated with the second byte.
- R5: Opcode 0xC9 is the absolute form. It is 3 bytes long and takes 4 cycles. It reads the 16-bit address whose high byte comes first.
- R6: Opcode 0xD9 is indexed with a 16-bit offset (high byte first). It is 3 bytes long and takes 4 cycles, and it reads (index + offset) mod 2^16.
- R7: Opcode 0xE9 is indexed with an 8-bit offset. It is 2 bytes long and takes 3 cycles. The offset is zero-extended and added to the index.
- R8: Opcode 0xF9 is indexed with no offset. It is 1 byte long, takes 3 cycles and reads the byte at the index.
- R9: Prefix 0x9E followed by 0xD9 is stack-relative with a 16-bit offset. It is 4 bytes long and takes 5 cycles, and it reads (SP + offset) mod 2^16.
- R10: Prefix 0x9E followed by 0xE9 is stack-relative with an 8-bit offset. It is 3 bytes long and takes 4 cycles. The offset is zero-extended and added to SP.
- R11: A byte requested with mem_rd high at mem_addr must be on mem_rdata in the next cycle. After reset there is one opcode-fetch cycle at the starting PC. insn_done pulses for one cycle after each instruction, and successive pulses are spaced by the cycle count of the later instruction. On each pulse the program counter has advanced by the instruction length.
- R12: While rst_n is low at a clock edge, the block loads pc, the index, SP, the accumulator and flag_c from the init ports. It also clears flag_v, flag_n, flag_z, flag_h, insn_done and illegal.
- R13: An unknown opcode, or an unknown byte after the prefix, raises illegal in the following cycle and keeps it high until reset. After that the block issues no reads, and acc, pc and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset that loads the start state |
| init_pc | input | AW | Program counter loaded at reset |
| init_hx | input | AW | Index register loaded at reset |
| init_sp | input | AW | Stack pointer loaded at reset |
| init_a | input | 8 | Accumulator loaded at reset |
| init_c | input | 1 | Carry flag loaded at reset |
| mem_rd | output | 1 | Read request this cycle |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 8 | Byte requested in the previous cycle |
| acc | output | 8 | Accumulator |
| pc | output | AW | Program counter |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_h | output | 1 | Half-carry flag |
| insn_done | output | 1 | One-cycle pulse after each completed instruction |
| illegal | output | 1 | Sticky unknown-opcode indication |

## Verification
The bench builds the block with its default 16-bit address width. At that width, the index and stack sums that run past 0xFFFF wrap exactly as a 64 KiB memory needs, and an 8-bit offset above 0x7F shows whether it is zero-extended or sign-extended. Each mode runs back to back with the others so that the spacing between completion pulses checks the cycle count of every mode. Illegal first and second bytes halt the block at known cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DW     = 8;
  localparam int STEP_W = 3;

  localparam logic [7:0] OPC_IMM = 8'hA9;
  localparam logic [7:0] OPC_DIR = 8'hB9;
  localparam logic [7:0] OPC_EXT = 8'hC9;
  localparam logic [7:0] OPC_IX2 = 8'hD9;
  localparam logic [7:0] OPC_IX1 = 8'hE9;
  localparam logic [7:0] OPC_IX0 = 8'hF9;
  localparam logic [7:0] OPC_PFX = 8'h9E;

  typedef enum logic [3:0] {
    M_IMM, M_DIR, M_EXT, M_IX2, M_IX1, M_IX0, M_SP2, M_SP1, M_PFX, M_BAD
  } mode_e;

  typedef enum logic [1:0] {RD_NONE, RD_PC, RD_EA} rdsel_e;

  typedef enum logic [1:0] {S_PRIME, S_EXEC, S_HALT} state_e;

  typedef struct packed {
    rdsel_e      rd;
    logic [2:0]  pc_off;
    logic        lat_hi;
    logic        lat_lo;
    logic        last;
  } uop_t;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
    logic          n;
    logic          z;
    logic          h;
  } alu_t;

  function automatic mode_e decode_main(logic [7:0] op);
    case (op)
      OPC_IMM: return M_IMM;
      OPC_DIR: return M_DIR;
      OPC_EXT: return M_EXT;
      OPC_IX2: return M_IX2;
      OPC_IX1: return M_IX1;
      OPC_IX0: return M_IX0;
      OPC_PFX: return M_PFX;
      default: return M_BAD;
    endcase
  endfunction

  function automatic mode_e decode_pfx(logic [7:0] op);
    case (op)
      OPC_IX2: return M_SP2;
      OPC_IX1: return M_SP1;
      default: return M_BAD;
    endcase
  endfunction

  function automatic logic [2:0] mode_len(mode_e m);
    case (m)
      M_IX0:                      return 3'd1;
      M_IMM, M_DIR, M_IX1:        return 3'd2;
      M_EXT, M_IX2, M_SP1:        return 3'd3;
      M_SP2:                      return 3'd4;
      default:                    return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] mode_cycles(mode_e m);
    case (m)
      M_IMM:                      return 3'd2;
      M_DIR, M_IX1, M_IX0:        return 3'd3;
      M_EXT, M_IX2, M_SP1:        return 3'd4;
      M_SP2:                      return 3'd5;
      default:                    return 3'd0;
    endcase
  endfunction

  function automatic alu_t adc8(logic [DW-1:0] a, logic [DW-1:0] m, logic cin);
    alu_t       r;
    logic [8:0] full;
    logic [4:0] nib;
    full  = {1'b0, a} + {1'b0, m} + {8'd0, cin};
    nib   = {1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'd0, cin};
    r.res = full[7:0];
    r.c   = full[8];
    r.h   = nib[4];
    r.n   = full[7];
    r.z   = (full[7:0] == 8'h00);
    r.v   = (a[7] & m[7] & ~full[7]) | (~a[7] & ~m[7] & full[7]);
    return r;
  endfunction

endpackage

// File: rtl/adc_seq_decode.sv
module adc_seq_decode
  import adc_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  mode_e             mode_q,
  input  logic [7:0]        rdata,
  output mode_e             eff_mode,
  output uop_t              uop
);

  function automatic uop_t plan(mode_e m, logic [STEP_W-1:0] s);
    uop_t u;
    u    = '0;
    u.rd = RD_NONE;
    case (m)
      M_IMM: begin
        if (s == 3'd0) begin u.rd = RD_PC; u.pc_off = 3'd1; end
      end
      M_DIR, M_IX1: begin
        case (s)
          3'd0: begin u.rd = RD_PC; u.pc_off = 3'd1; end
          3'd1: begin u.lat_lo = 1'b1; u.rd = RD_EA; end
          default: ;
        endcase
      end
      M_EXT, M_IX2: begin
        case (s)
          3'd0: begin u.rd = RD_PC; u.pc_off = 3'd1; end
          3'd1: begin u.lat_hi = 1'b1; u.rd = RD_PC; u.pc_off = 3'd2; end
          3'd2: begin u.lat_lo = 1'b1; u.rd = RD_EA; end
          default: ;
        endcase
      end
      M_IX0: begin
        if (s == 3'd1) u.rd = RD_EA;
      end
      M_PFX: begin
        if (s == 3'd0) begin u.rd = RD_PC; u.pc_off = 3'd1; end
      end
      M_SP2: begin
        case (s)
          3'd1: begin u.rd = RD_PC; u.pc_off = 3'd2; end
          3'd2: begin u.lat_hi = 1'b1; u.rd = RD_PC; u.pc_off = 3'd3; end
          3'd3: begin u.lat_lo = 1'b1; u.rd = RD_EA; end
          default: ;
        endcase
      end
      M_SP1: begin
        case (s)
          3'd1: begin u.rd = RD_PC; u.pc_off = 3'd2; end
          3'd2: begin u.lat_lo = 1'b1; u.rd = RD_EA; end
          default: ;
        endcase
      end
      default: ;
    endcase
    if (m != M_PFX && m != M_BAD && s == mode_cycles(m) - 3'd1) begin
      u.last   = 1'b1;
      u.rd     = RD_PC;
      u.pc_off = mode_len(m);
    end
    return u;
  endfunction

  always_comb begin
    if (step == '0)
      eff_mode = decode_main(rdata);
    else if (mode_q == M_PFX)
      eff_mode = decode_pfx(rdata);
    else
      eff_mode = mode_q;
    uop = plan(eff_mode, step);
  end

endmodule

// File: rtl/adc_seq_agen.sv
module adc_seq_agen
  import adc_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  uop_t          uop,
  input  mode_e         mode,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] hx,
  input  logic [AW-1:0] sp,
  input  logic [7:0]    hi,
  input  logic [7:0]    lo,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] off_w;
  logic [AW-1:0] off_b;
  logic [AW-1:0] ea;

  always_comb begin
    off_w = AW'({hi, lo});
    off_b = AW'(lo);
    case (mode)
      M_DIR:   ea = off_b;
      M_EXT:   ea = off_w;
      M_IX2:   ea = hx + off_w;
      M_IX1:   ea = hx + off_b;
      M_IX0:   ea = hx;
      M_SP2:   ea = sp + off_w;
      M_SP1:   ea = sp + off_b;
      default: ea = '0;
    endcase
    addr = (uop.rd == RD_EA) ? ea : pc + AW'(uop.pc_off);
  end

endmodule

// File: rtl/adc_seq_alu.sv
module adc_seq_alu
  import adc_seq_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  output alu_t          q
);

  always_comb q = adc8(a, m, cin);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] init_pc,
  input  logic [AW-1:0] init_hx,
  input  logic [AW-1:0] init_sp,
  input  logic [7:0]    init_a,
  input  logic          init_c,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    acc,
  output logic [AW-1:0] pc,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_h,
  output logic          insn_done,
  output logic          illegal
);

  state_e              state;
  mode_e               mode_q;
  mode_e               eff_mode;
  uop_t                uop;
  alu_t                alu_q;
  logic [STEP_W-1:0]   step;
  logic [AW-1:0]       pc_q, hx_q, sp_q;
  logic [7:0]          a_q, hi_q, lo_q, lo_now;
  logic                c_q, v_q, n_q, z_q, h_q;
  logic                done_q, illegal_q;
  logic [AW-1:0]       agen_addr;

  // Named events for the checker
  logic                commit_evt;
  logic                halt_evt;

  adc_seq_decode u_dec (
    .step     (step),
    .mode_q   (mode_q),
    .rdata    (mem_rdata),
    .eff_mode (eff_mode),
    .uop      (uop)
  );

  assign lo_now = uop.lat_lo ? mem_rdata : lo_q;

  adc_seq_agen #(.AW(AW)) u_agen (
    .uop  (uop),
    .mode (eff_mode),
    .pc   (pc_q),
    .hx   (hx_q),
    .sp   (sp_q),
    .hi   (hi_q),
    .lo   (lo_now),
    .addr (agen_addr)
  );

  adc_seq_alu u_alu (
    .a   (a_q),
    .m   (mem_rdata),
    .cin (c_q),
    .q   (alu_q)
  );

  assign halt_evt   = (state == S_EXEC) && (eff_mode == M_BAD);
  assign commit_evt = (state == S_EXEC) && (eff_mode != M_BAD) && uop.last;

  assign mem_rd   = (state == S_PRIME) ||
                    ((state == S_EXEC) && (eff_mode != M_BAD) && (uop.rd != RD_NONE));
  assign mem_addr = (state == S_PRIME) ? pc_q : agen_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_PRIME;
      mode_q    <= M_IMM;
      step      <= '0;
      pc_q      <= init_pc;
      hx_q      <= init_hx;
      sp_q      <= init_sp;
      a_q       <= init_a;
      c_q       <= init_c;
      v_q       <= 1'b0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      h_q       <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_PRIME: begin
          state <= S_EXEC;
          step  <= '0;
        end
        S_EXEC: begin
          if (halt_evt) begin
            state     <= S_HALT;
            illegal_q <= 1'b1;
          end else begin
            mode_q <= eff_mode;
            if (uop.lat_hi) hi_q <= mem_rdata;
            if (uop.lat_lo) lo_q <= mem_rdata;
            if (commit_evt) begin
              a_q    <= alu_q.res;
              c_q    <= alu_q.c;
              v_q    <= alu_q.v;
              n_q    <= alu_q.n;
              z_q    <= alu_q.z;
              h_q    <= alu_q.h;
              pc_q   <= pc_q + AW'(mode_len(eff_mode));
              step   <= '0;
              done_q <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign acc       = a_q;
  assign pc        = pc_q;
  assign flag_c    = c_q;
  assign flag_v    = v_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign flag_h    = h_q;
  assign insn_done = done_q;
  assign illegal   = illegal_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [7:0]    acc,
  input logic [AW-1:0] pc,
  input logic          flag_z,
  input logic          flag_n,
  input logic          insn_done,
  input logic          illegal,
  input logic          commit_evt
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal); // R13

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_rd); // R13

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |-> (flag_z == (acc == 8'h00))); // R2

  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |-> (flag_n == acc[7])); // R2

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !insn_done) |-> $stable(acc)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && insn_done) |-> ((pc - $past(pc)) >= AW'(1) && (pc - $past(pc)) <= AW'(4))); // R11

  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |=> !insn_done); // R11

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> insn_done); // R11

endmodule

bind adc_seq adc_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd     (mem_rd),
  .acc        (acc),
  .pc         (pc),
  .flag_z     (flag_z),
  .flag_n     (flag_n),
  .insn_done  (insn_done),
  .illegal    (illegal),
  .commit_evt (commit_evt)
);

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int CLK_NS = 10;
  localparam int AW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] init_pc = '0, init_hx = '0, init_sp = '0;
  logic [7:0]    init_a = '0;
  logic          init_c = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;
  logic [7:0]    acc;
  logic [AW-1:0] pc;
  logic          flag_c, flag_v, flag_n, flag_z, flag_h, insn_done, illegal;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] mem [logic [15:0]];
  logic [15:0] wp;

  adc_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .init_pc(init_pc), .init_hx(init_hx), .init_sp(init_sp),
    .init_a(init_a), .init_c(init_c), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .acc(acc), .pc(pc), .flag_c(flag_c), .flag_v(flag_v),
    .flag_n(flag_n), .flag_z(flag_z), .flag_h(flag_h), .insn_done(insn_done),
    .illegal(illegal)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] peek(logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= peek(mem_addr);

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[wp] = b;
    wp = wp + 16'd1;
  endtask

  // Reference model: integer arithmetic, signed range test for overflow
  int m_a, m_c, m_v, m_n, m_z, m_h;
  task automatic model(input int opnd);
    int sum, sa, sm, ssum;
    sum  = m_a + opnd + m_c;
    sa   = (m_a >= 128) ? m_a - 256 : m_a;
    sm   = (opnd >= 128) ? opnd - 256 : opnd;
    ssum = sa + sm + m_c;
    m_h  = (((m_a % 16) + (opnd % 16) + m_c) > 15) ? 1 : 0;
    m_v  = (ssum > 127 || ssum < -128) ? 1 : 0;
    m_c  = (sum > 255) ? 1 : 0;
    m_a  = sum % 256;
    m_n  = (m_a >= 128) ? 1 : 0;
    m_z  = (m_a == 0) ? 1 : 0;
  endtask

  task automatic do_reset(input logic [15:0] p, input logic [15:0] x, input logic [15:0] s,
                          input logic [7:0] a, input logic c);
    @(negedge clk);
    rst_n = 1'b0; init_pc = p; init_hx = x; init_sp = s; init_a = a; init_c = c;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_a = a; m_c = c; m_v = 0; m_n = 0; m_z = 0; m_h = 0;
    // R12: state loaded from init ports, status cleared
    check("R12", "acc", acc, a);
    check("R12", "pc", pc, p);
    check("R12", "flag_c", flag_c, c);
    check("R12", "vnzh", {flag_v, flag_n, flag_z, flag_h}, 0);
    check("R12", "done/illegal", {insn_done, illegal}, 0);
    // R11: priming opcode fetch at the start address
    check("R11", "prime rd", mem_rd, 1);
    check("R11", "prime addr", mem_addr, p);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!insn_done && cyc < 100);
  endtask

  task automatic check_state(input string req);
    check(req, "acc", acc, m_a);
    check("R1", "flag_c", flag_c, m_c);
    check("R2", "flag_v", flag_v, m_v);
    check("R2", "flag_n", flag_n, m_n);
    check("R2", "flag_z", flag_z, m_z);
    check("R2", "flag_h", flag_h, m_h);
  endtask

  task automatic test_all_modes();
    int cyc_tab[8] = '{2, 3, 4, 4, 3, 3, 5, 4};
    int len_tab[8] = '{2, 2, 3, 3, 2, 1, 4, 3};
    int opd_tab[8] = '{'hAA, 'h8F, 'h11, 'h40, 'h74, 'h50, 'h01, 'hC4};
    string tag_tab[8] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};
    int total, cyc, exp_pc;
    mem.delete();
    wp = 16'h1860;
    emit(8'hA9); emit(8'hAA);
    emit(8'hB9); emit(8'hFF);
    emit(8'hC9); emit(8'hFF); emit(8'h11);
    emit(8'hD9); emit(8'hFF); emit(8'hF0);
    emit(8'hE9); emit(8'h24);
    emit(8'hF9);
    emit(8'h9E); emit(8'hD9); emit(8'hFF); emit(8'h61);
    emit(8'h9E); emit(8'hE9); emit(8'h24);
    mem[16'h00FF] = 8'h8F; mem[16'hFF11] = 8'h11; mem[16'hFF40] = 8'h40;
    mem[16'hFF74] = 8'h74; mem[16'hFF50] = 8'h50; mem[16'h0071] = 8'h01;
    mem[16'h0134] = 8'hC4;
    do_reset(16'h1860, 16'hFF50, 16'h0110, 8'h00, 1'b1);
    total  = 0;
    exp_pc = 'h1860;
    for (int i = 0; i < 8; i++) begin
      wait_done(cyc);
      if (i == 0) cyc = cyc - 1;  // R11: one priming cycle before the first instruction
      total += cyc;
      check(tag_tab[i], "cycles", cyc, cyc_tab[i]);
      model(opd_tab[i]);
      exp_pc += len_tab[i];
      check(tag_tab[i], "pc", pc, exp_pc);
      check_state(tag_tab[i]);
    end
    check("R11", "total cycles", total, 28);
    check("R1", "final acc", acc, 'h16);
    check("R11", "final pc", pc, 'h1874);
    check("R1", "final C", flag_c, 1);
    check("R2", "final VNZ", {flag_v, flag_n, flag_z}, 0);
  endtask

  task automatic test_flags();
    int opd_tab[4] = '{'h01, 'h80, 'h0F, 'hFF};
    int cyc;
    mem.delete();
    wp = 16'h0200;
    for (int i = 0; i < 4; i++) begin emit(8'hA9); emit(8'(opd_tab[i])); end
    do_reset(16'h0200, 16'h0000, 16'h0000, 8'h7F, 1'b0);
    for (int i = 0; i < 4; i++) begin
      wait_done(cyc);
      model(opd_tab[i]);
      check_state("R1");
    end
    // expected: 80 V N H / 00 C Z V / 10 H / 0F C
    check("R2", "last result", acc, 'h0F);
  endtask

  task automatic test_offsets();
    int opd_tab[4] = '{'h05, 'h06, 'h07, 'h08};
    string tag_tab[4] = '{"R7", "R10", "R5", "R6"};
    int cyc;
    mem.delete();
    wp = 16'h0300;
    emit(8'hE9); emit(8'hF0);                  // index 0x0010 + 0xF0 -> 0x0100
    emit(8'h9E); emit(8'hE9); emit(8'h80);     // SP 0x0100 + 0x80 -> 0x0180
    emit(8'hC9); emit(8'h12); emit(8'h34);     // absolute 0x1234
    emit(8'hD9); emit(8'h00); emit(8'h20);     // index 0x0010 + 0x0020
    mem[16'h0100] = 8'h05; mem[16'h0180] = 8'h06;
    mem[16'h1234] = 8'h07; mem[16'h0030] = 8'h08;
    mem[16'h3412] = 8'hEE; mem[16'hFF80] = 8'hEE; mem[16'h0000] = 8'hEE;
    do_reset(16'h0300, 16'h0010, 16'h0100, 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) begin
      wait_done(cyc);
      model(opd_tab[i]);
      check_state(tag_tab[i]);
    end
    check("R11", "pc", pc, 'h030B);
  endtask

  task automatic test_illegal();
    int cyc;
    mem.delete();
    wp = 16'h0400;
    emit(8'hA9); emit(8'h01); emit(8'h00);
    do_reset(16'h0400, 16'h0000, 16'h0000, 8'h10, 1'b0);
    wait_done(cyc);
    check("R13", "illegal before decode", illegal, 0);
    @(negedge clk);
    check("R13", "illegal raised", illegal, 1);
    check("R13", "no read", mem_rd, 0);
    repeat (5) @(negedge clk);
    check("R13", "illegal held", illegal, 1);
    check("R13", "acc held", acc, 'h11);
    check("R13", "pc held", pc, 'h0402);
    check("R13", "no read later", mem_rd, 0);
    check("R13", "done quiet", insn_done, 0);

    mem.delete();
    wp = 16'h0500;
    emit(8'h9E); emit(8'h00);
    do_reset(16'h0500, 16'h0000, 16'h0000, 8'h22, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R13", "prefix pending", illegal, 0);
    @(negedge clk);
    check("R13", "bad after prefix", illegal, 1);
    check("R13", "pc after prefix", pc, 'h0500);
    check("R13", "acc after prefix", acc, 'h22);
    check("R13", "carry after prefix", flag_c, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    test_all_modes();
    test_flags();
    test_offsets();
    test_illegal();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule